// File: doc/BRIEF.md
# Full-Frame Imager Readout Clock Sequencer

This block produces the digital timing waveforms that drain a full-frame charge-coupled imager after an exposure. On a start command it keeps the vertical electrodes static for a programmable integration time. It then reads every row of the array. For each output line, the block clocks one or more rows down the three-phase vertical register. Each row is tipped into the horizontal register through a gated transfer. After a short settle, the line is shifted out with the two-phase horizontal clocks.

Each horizontal line is longer than the active row. Dummy and isolation stages pad it on both sides. A pixel-valid strobe, with a row and column index, marks only the active positions so that a downstream converter can capture samples. A shutter-close request covers the whole readout, and a one-cycle frame-done flag closes the frame. Level shifting, biasing and the analog chain are outside the block.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset and while idle, the vertical phases read V1=1, V2=1, V3=0; the transfer gate is 0; H1 is 1 and H2 is 0; shutter-close, pixel-valid and frame-done are all 0.
- R2: A start seen while idle begins integration. Integration lasts max(intLen,1) clock cycles. During it, shutter-close stays 0 and the vertical phases hold at V1=1, V2=1, V3=0.
- R3: Each vertical row shift steps {V1,V2,V3} through 110, 010, 011, 001, 101, 100 and then back to 110. Each non-hold step lasts STEP_CLKS cycles. Exactly one or two phases are high at any time.
- R4: The transfer gate is high only between vertical shifts, for TG_CLKS cycles per row, while the vertical phases hold at 110. A frame has ROWS×TG_CLKS gate-high cycles in total.
- R5: H2 is always the complement of H1, and H1 stays high whenever no line is being shifted.
- R6: At least SETTLE_CLKS full cycles pass between the transfer gate falling and the first falling edge of H1 in a line.
- R7: A line has DUMMY+LEAD_ISO+ACTIVE_COLS+TRAIL_ISO horizontal periods of two cycles each, with H1 high first. Pixel-valid is high in the H1-low half of the periods from DUMMY+LEAD_ISO up to DUMMY+LEAD_ISO+ACTIVE_COLS-1. Column index counts 0 to ACTIVE_COLS-1 in order.
- R8: The binning factor is captured at start, and a value of 0 acts as 1. Each line holds min(bin, rows remaining) vertical shifts, so the last bin may be partial. There are ceil(ROWS/bin) lines, and the row index equals the line number starting from 0.
- R9: Shutter-close rises when integration ends and stays high up to and including the frame-done cycle. It is low in the cycle after that.
- R10: Frame-done is high for exactly one cycle, max(intLen,1) + ROWS×(6×STEP_CLKS+TG_CLKS) + lines×(SETTLE_CLKS+2×line periods) + 1 cycles after start is captured. A start, intLen or binning change during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (honoured only when idle) |
| intLen | input | INT_W | Integration length in clocks |
| binFactor | input | BIN_W | Rows summed per output line (0 treated as 1) |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| v3 | output | 1 | Vertical phase 3 |
| tg | output | 1 | Vertical-to-horizontal transfer gate |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| shutterClose | output | 1 | Request to keep the shutter shut |
| pixValid | output | 1 | Active pixel present at the output |
| rowIdx | output | $clog2(ROWS+1) | Output line number |
| colIdx | output | $clog2(ACTIVE_COLS) | Active column number (0 when not valid) |
| frameDone | output | 1 | One-cycle end-of-frame flag |

## Verification
The bench builds the sequencer with 7 rows, 6 active columns, 2 dummy stages, 3 leading and 3 trailing isolation stages, and 2-cycle step, gate and settle times. A whole frame is then a few hundred cycles. Binning factors of 0, 1, 2, 3, the full row count and more than the row count are all reachable. Seven rows is prime, so every factor from 2 to 6 leaves a partial last bin. The short line puts the padding boundaries on both sides of the active window only a few periods apart.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_VSHIFT,
    ST_XFER,
    ST_SETTLE,
    ST_HSHIFT,
    ST_DONE
  } seqState_t;

  // control -> datapath strobes and levels
  typedef struct packed {
    logic frameLoad;
    logic lineStart;
    logic vRestart;
    logic stepAdv;
    logic xferLoad;
    logic rowDone;
    logic settleLoad;
    logic hStart;
    logic lineEnd;
    logic vActive;
    logic xferActive;
    logic hActive;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic tmrLast;
    logic vLastStep;
    logic binRowsLast;
    logic lineLastHalf;
    logic lastLine;
  } seqStatus_t;

endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t sts,
  output seqStrobe_t str,
  output logic       shutterClose,
  output logic       frameDone
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    str            = '0;
    nextState      = state;
    str.vActive    = (state == ST_VSHIFT);
    str.xferActive = (state == ST_XFER);
    str.hActive    = (state == ST_HSHIFT);
    case (state)
      ST_IDLE: begin
        if (start) begin
          str.frameLoad = 1'b1;
          nextState     = ST_INTEG;
        end
      end
      ST_INTEG: begin
        if (sts.tmrLast) begin
          str.lineStart = 1'b1;
          nextState     = ST_VSHIFT;
        end
      end
      ST_VSHIFT: begin
        if (sts.tmrLast) begin
          if (sts.vLastStep) begin
            str.xferLoad = 1'b1;
            nextState    = ST_XFER;
          end else begin
            str.stepAdv = 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (sts.tmrLast) begin
          str.rowDone = 1'b1;
          if (sts.binRowsLast) begin
            str.settleLoad = 1'b1;
            nextState      = ST_SETTLE;
          end else begin
            str.vRestart = 1'b1;
            nextState    = ST_VSHIFT;
          end
        end
      end
      ST_SETTLE: begin
        if (sts.tmrLast) begin
          str.hStart = 1'b1;
          nextState  = ST_HSHIFT;
        end
      end
      ST_HSHIFT: begin
        if (sts.lineLastHalf) begin
          str.lineEnd = 1'b1;
          if (sts.lastLine) begin
            nextState = ST_DONE;
          end else begin
            str.lineStart = 1'b1;
            nextState     = ST_VSHIFT;
          end
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign shutterClose = (state == ST_VSHIFT) || (state == ST_XFER) ||
                        (state == ST_SETTLE) || (state == ST_HSHIFT) ||
                        (state == ST_DONE);
  assign frameDone    = (state == ST_DONE);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R9
  shutter_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shutterClose && !frameDone) |=> shutterClose);

endmodule

// File: rtl/ccd_seq_dp.sv
module ccd_seq_dp
  import ccd_seq_pkg::*;
#(
  parameter int ROWS        = 330,
  parameter int ACTIVE_COLS = 1100,
  parameter int DUMMY       = 3,
  parameter int LEAD_ISO    = 16,
  parameter int TRAIL_ISO   = 16,
  parameter int STEP_CLKS   = 4,
  parameter int TG_CLKS     = 4,
  parameter int SETTLE_CLKS = 2,
  parameter int INT_W       = 24,
  parameter int BIN_W       = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [INT_W-1:0]               intLen,
  input  logic [BIN_W-1:0]               binFactor,
  input  seqStrobe_t                     str,
  output seqStatus_t                     sts,
  output logic                           v1,
  output logic                           v2,
  output logic                           v3,
  output logic                           tg,
  output logic                           h1,
  output logic                           h2,
  output logic                           pixValid,
  output logic [$clog2(ROWS+1)-1:0]      rowIdx,
  output logic [$clog2(ACTIVE_COLS)-1:0] colIdx
);

  localparam int LINE    = DUMMY + LEAD_ISO + ACTIVE_COLS + TRAIL_ISO;
  localparam int FIRST   = DUMMY + LEAD_ISO;
  localparam int ROW_W   = $clog2(ROWS + 1);
  localparam int COL_W   = $clog2(ACTIVE_COLS);
  localparam int HALF_W  = $clog2(2 * LINE);
  localparam int POS_W   = HALF_W - 1;
  localparam int CW      = (ROW_W > BIN_W) ? ROW_W : BIN_W;
  localparam int TMR_W   = INT_W;
  localparam logic [TMR_W-1:0]  STEP_T  = TMR_W'(STEP_CLKS);
  localparam logic [TMR_W-1:0]  TG_T    = TMR_W'(TG_CLKS);
  localparam logic [TMR_W-1:0]  SET_T   = TMR_W'(SETTLE_CLKS);
  localparam logic [POS_W:0]    FIRST_P = (POS_W+1)'(FIRST);
  localparam logic [POS_W:0]    END_P   = (POS_W+1)'(FIRST + ACTIVE_COLS);
  localparam logic [HALF_W-1:0] LAST_H  = HALF_W'(2 * LINE - 1);

  logic [TMR_W-1:0]  tmr;
  logic [2:0]        vStep;
  logic [BIN_W-1:0]  binReg;
  logic [ROW_W-1:0]  rowsLeft;
  logic [ROW_W-1:0]  lineIdx;
  logic [CW-1:0]     binCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [CW-1:0]     rowsLeftX, binX, binThis;
  logic [POS_W:0]    posX;
  logic              inActive;
  logic [2:0]        vPat;

  // shared down-counter for integration, steps, gate and settle
  always_ff @(posedge clk) begin
    if (!rstN)                                     tmr <= '0;
    else if (str.frameLoad)                        tmr <= (intLen == '0) ? TMR_W'(1) : intLen;
    else if (str.lineStart || str.vRestart || str.stepAdv) tmr <= STEP_T;
    else if (str.xferLoad)                         tmr <= TG_T;
    else if (str.settleLoad)                       tmr <= SET_T;
    else if (tmr != '0)                            tmr <= tmr - TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vStep    <= '0;
      binReg   <= BIN_W'(1);
      rowsLeft <= '0;
      lineIdx  <= '0;
      binCnt   <= '0;
      halfCnt  <= '0;
    end else begin
      if (str.lineStart || str.vRestart) vStep <= '0;
      else if (str.stepAdv)              vStep <= vStep + 3'd1;

      if (str.frameLoad) binReg <= (binFactor == '0) ? BIN_W'(1) : binFactor;

      if (str.frameLoad) begin
        rowsLeft <= ROW_W'(ROWS);
        lineIdx  <= '0;
      end else if (str.lineEnd) begin
        rowsLeft <= ROW_W'(rowsLeftX - binThis);
        lineIdx  <= lineIdx + ROW_W'(1);
      end

      if (str.lineStart)    binCnt <= '0;
      else if (str.rowDone) binCnt <= binCnt + CW'(1);

      if (str.hStart)       halfCnt <= '0;
      else if (str.hActive) halfCnt <= halfCnt + HALF_W'(1);
    end
  end

  // rows gathered in the current line: a partial bin at the frame end
  assign rowsLeftX = CW'(rowsLeft);
  assign binX      = CW'(binReg);
  assign binThis   = (rowsLeftX < binX) ? rowsLeftX : binX;

  assign sts.tmrLast      = (tmr == TMR_W'(1));
  assign sts.vLastStep    = (vStep == 3'd5);
  assign sts.binRowsLast  = (binCnt == binThis - CW'(1));
  assign sts.lineLastHalf = (halfCnt == LAST_H);
  assign sts.lastLine     = (rowsLeftX <= binX);

  // vertical phase pattern {v1,v2,v3}
  always_comb begin
    vPat = 3'b110;
    if (str.vActive) begin
      case (vStep)
        3'd0:    vPat = 3'b110;
        3'd1:    vPat = 3'b010;
        3'd2:    vPat = 3'b011;
        3'd3:    vPat = 3'b001;
        3'd4:    vPat = 3'b101;
        default: vPat = 3'b100;
      endcase
    end
  end

  assign v1 = vPat[2];
  assign v2 = vPat[1];
  assign v3 = vPat[0];
  assign tg = str.xferActive;
  assign h1 = ~(str.hActive & halfCnt[0]);
  assign h2 = ~h1;

  assign posX     = {1'b0, halfCnt[HALF_W-1:1]};
  assign inActive = (posX >= FIRST_P) && (posX < END_P);
  assign pixValid = str.hActive & halfCnt[0] & inActive;
  assign colIdx   = pixValid ? COL_W'(posX - FIRST_P) : '0;
  assign rowIdx   = lineIdx;

  // R3
  v_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({v1, v2, v3}) == 1) || ($countones({v1, v2, v3}) == 2));

  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    tg |-> (v1 && v2 && !v3));

  // R6
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(h1) |-> (!$past(tg) && !$past(tg, 2)));

  // R7
  pix_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> !h1);

  // R8
  bin_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.lineEnd |-> (binCnt == binThis));

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int ROWS        = 330,
  parameter int ACTIVE_COLS = 1100,
  parameter int DUMMY       = 3,
  parameter int LEAD_ISO    = 16,
  parameter int TRAIL_ISO   = 16,
  parameter int STEP_CLKS   = 4,
  parameter int TG_CLKS     = 4,
  parameter int SETTLE_CLKS = 2,
  parameter int INT_W       = 24,
  parameter int BIN_W       = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [INT_W-1:0]               intLen,
  input  logic [BIN_W-1:0]               binFactor,
  output logic                           v1,
  output logic                           v2,
  output logic                           v3,
  output logic                           tg,
  output logic                           h1,
  output logic                           h2,
  output logic                           shutterClose,
  output logic                           pixValid,
  output logic [$clog2(ROWS+1)-1:0]      rowIdx,
  output logic [$clog2(ACTIVE_COLS)-1:0] colIdx,
  output logic                           frameDone
);

  seqStrobe_t str;
  seqStatus_t sts;

  ccd_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .sts          (sts),
    .str          (str),
    .shutterClose (shutterClose),
    .frameDone    (frameDone)
  );

  ccd_seq_dp #(
    .ROWS        (ROWS),
    .ACTIVE_COLS (ACTIVE_COLS),
    .DUMMY       (DUMMY),
    .LEAD_ISO    (LEAD_ISO),
    .TRAIL_ISO   (TRAIL_ISO),
    .STEP_CLKS   (STEP_CLKS),
    .TG_CLKS     (TG_CLKS),
    .SETTLE_CLKS (SETTLE_CLKS),
    .INT_W       (INT_W),
    .BIN_W       (BIN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .intLen    (intLen),
    .binFactor (binFactor),
    .str       (str),
    .sts       (sts),
    .v1        (v1),
    .v2        (v2),
    .v3        (v3),
    .tg        (tg),
    .h1        (h1),
    .h2        (h2),
    .pixValid  (pixValid),
    .rowIdx    (rowIdx),
    .colIdx    (colIdx)
  );

endmodule

// File: tb/ccd_readout_seq_bench.sv
module ccd_readout_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int P_ROWS  = 7;
  localparam int P_ACT   = 6;
  localparam int P_DUM   = 2;
  localparam int P_LEAD  = 3;
  localparam int P_TRAIL = 3;
  localparam int P_STEP  = 2;
  localparam int P_TG    = 2;
  localparam int P_SET   = 2;
  localparam int P_INTW  = 8;
  localparam int P_BINW  = 4;
  localparam int LINE    = P_DUM + P_LEAD + P_ACT + P_TRAIL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [P_INTW-1:0] intLen = '0;
  logic [P_BINW-1:0] binFactor = '0;
  logic v1, v2, v3, tg, h1, h2, shutterClose, pixValid, frameDone;
  logic [$clog2(P_ROWS+1)-1:0] rowIdx;
  logic [$clog2(P_ACT)-1:0]    colIdx;

  ccd_readout_seq #(
    .ROWS(P_ROWS), .ACTIVE_COLS(P_ACT), .DUMMY(P_DUM), .LEAD_ISO(P_LEAD),
    .TRAIL_ISO(P_TRAIL), .STEP_CLKS(P_STEP), .TG_CLKS(P_TG),
    .SETTLE_CLKS(P_SET), .INT_W(P_INTW), .BIN_W(P_BINW)
  ) u_ccd_readout_seq (
    .clk(clk), .rstN(rstN), .start(start), .intLen(intLen),
    .binFactor(binFactor), .v1(v1), .v2(v2), .v3(v3), .tg(tg), .h1(h1),
    .h2(h2), .shutterClose(shutterClose), .pixValid(pixValid),
    .rowIdx(rowIdx), .colIdx(colIdx), .frameDone(frameDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] v_succ(input logic [2:0] p);
    case (p)
      3'b110:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b001;
      3'b001:  return 3'b101;
      3'b101:  return 3'b100;
      3'b100:  return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int eff_bin(input int b);
    return (b == 0) ? 1 : b;
  endfunction

  function automatic int exp_lines(input int b);
    return (P_ROWS + eff_bin(b) - 1) / eff_bin(b);
  endfunction

  function automatic int exp_total(input int il, input int b);
    int n = (il == 0) ? 1 : il;
    return n + P_ROWS * (6 * P_STEP + P_TG) + exp_lines(b) * (P_SET + 2 * LINE) + 1;
  endfunction

  // frame parameters as requested at start
  int curInt = 0;
  int curBin = 0;

  // monitor state
  bit   armed = 0;
  bit   afterDone = 0;
  bit   shutSeen = 0;
  int   cycCnt, integCnt, lineNo, pixLine, tgLine, tgTotal, remRows;
  int   runLen = 0;
  int   sinceTg = 100;
  logic [2:0] prevV = 3'b110;
  logic prevTg = 1'b0;
  logic prevH1 = 1'b1;

  task finalize_line();
    int k;
    k = (remRows < eff_bin(curBin)) ? remRows : eff_bin(curBin);
    chk(pixLine == P_ACT, "R7 active pixels per line", pixLine, P_ACT);
    chk(tgLine == k * P_TG, "R8 gate cycles per line (bin)", tgLine, k * P_TG);
    remRows -= k;
    lineNo++;
    pixLine = 0;
    tgLine  = 0;
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [2:0] vNow;
      vNow = {v1, v2, v3};
      chk(h2 == ~h1, "R5 h2 complements h1", int'(h2), int'(~h1));
      if (vNow != prevV) begin
        chk(vNow == v_succ(prevV), "R3 vertical step order", int'(vNow), int'(v_succ(prevV)));
        if (prevV != 3'b110)
          chk(runLen == P_STEP, "R3 step length", runLen, P_STEP);
        runLen = 1;
      end else begin
        runLen++;
      end
      if (pixValid) chk(!h1, "R7 pixel in h1-low half", int'(h1), 0);
      if (prevH1 && !h1)
        chk(sinceTg >= P_SET + 1, "R6 settle before h clocking", sinceTg, P_SET + 1);

      if (afterDone) begin
        chk(!shutterClose && !frameDone, "R9 shutter released after done",
            int'({shutterClose, frameDone}), 0);
        afterDone = 0;
      end

      if (!armed) begin
        chk(h1 && !tg, "R5 h1 parked high when idle", int'({h1, tg}), 2);
        if (start) begin
          armed = 1; cycCnt = 0; integCnt = 0; shutSeen = 0; lineNo = 0;
          pixLine = 0; tgLine = 0; tgTotal = 0; remRows = P_ROWS;
        end
      end else begin
        cycCnt++;
        if (!shutSeen) begin
          if (!shutterClose) begin
            integCnt++;
            chk(vNow == 3'b110 && !tg, "R2 static electrodes in integration", int'(vNow), 6);
          end else begin
            shutSeen = 1;
            chk(integCnt == ((curInt == 0) ? 1 : curInt), "R2 integration length",
                integCnt, (curInt == 0) ? 1 : curInt);
          end
        end else begin
          chk(shutterClose, "R9 shutter held during readout", int'(shutterClose), 1);
        end
        if (tg && !prevTg && pixLine > 0) finalize_line();
        if (tg) begin
          tgLine++;
          tgTotal++;
        end
        if (pixValid) begin
          chk(int'(rowIdx) == lineNo, "R8 row index", int'(rowIdx), lineNo);
          chk(int'(colIdx) == pixLine, "R7 column index", int'(colIdx), pixLine);
          pixLine++;
        end
        if (frameDone) begin
          finalize_line();
          chk(cycCnt == exp_total(curInt, curBin), "R10 frame length",
              cycCnt, exp_total(curInt, curBin));
          chk(lineNo == exp_lines(curBin), "R8 line count", lineNo, exp_lines(curBin));
          chk(remRows == 0, "R8 all rows consumed", remRows, 0);
          chk(tgTotal == P_ROWS * P_TG, "R4 total gate cycles", tgTotal, P_ROWS * P_TG);
          armed = 0;
          afterDone = 1;
        end
      end
      sinceTg = tg ? 0 : sinceTg + 1;
      prevTg = tg;
      prevH1 = h1;
      prevV  = vNow;
    end
  end

  task automatic run_frame(input int il, input int b, input bit poke);
    int wd = 0;
    @(posedge clk); #1;
    intLen = P_INTW'(il); binFactor = P_BINW'(b);
    curInt = il; curBin = b;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R10: start and new settings mid-frame must be ignored
      repeat (40) @(posedge clk);
      #1;
      start = 1'b1; intLen = P_INTW'(il + 17); binFactor = P_BINW'(1);
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (armed && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (wd >= 5000) chk(1'b0, "R10 frame never completed", wd, 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({v1, v2, v3} == 3'b110, "R1 idle vertical phases", int'({v1, v2, v3}), 6);
    chk(!tg && h1 && !h2, "R1 idle gate and horizontal", int'({tg, h1, h2}), 2);
    chk(!shutterClose && !pixValid && !frameDone, "R1 idle flags",
        int'({shutterClose, pixValid, frameDone}), 0);
    // directed corners
    run_frame(0, 1, 1'b0);
    run_frame(5, 2, 1'b0);
    run_frame(3, 3, 1'b0);
    run_frame(1, P_ROWS, 1'b0);
    run_frame(4, 0, 1'b0);
    run_frame(2, 15, 1'b0);
    run_frame(6, 2, 1'b1);
    // constrained random
    for (int i = 0; i < 8; i++) begin
      run_frame(int'($urandom_range(0, 30)), int'($urandom_range(0, 9)), 1'b0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired (R10) actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule